// File: doc/BRIEF.md
# Serial Audio Input Port

This block receives stereo PCM samples over a three-wire serial link made of a bit clock, a word clock that marks the left and right phases, and a data line. It puts each captured left/right pair out as two parallel words together with a one-cycle valid strobe. Static configuration inputs choose how the link is framed. They select the sample width, whether data sits at the start or the end of each word-clock phase, an optional one-bit gap before the most significant bit, which bit-clock edge samples data, and which word-clock level means left.

The port can drive the link clocks itself or follow clocks from a remote device. As clock master it divides the system clock into a bit clock and derives a word clock with a fixed number of bit periods per phase. As slave it takes both clocks from its inputs and synchronises them into the system-clock domain. The system clock must run at least four times faster than the bit clock. In both roles the same capture logic counts sampling edges. Because it never relies on a fixed clock ratio, uneven phase lengths and bursts of bit clock separated by pauses are accepted.

Top module: `pcm_rx_port`

## Requirements
- R1: While rst_n is low, sample_valid, left_data and right_data are zero, sck_out equals cfg_sck_inv and ws_out equals cfg_ws_inv.
- R2: With cfg_master=1, sck_out changes level every cfg_div+1 clk cycles, and ws_out changes every SLOT_BITS bit-clock periods, always on a launch edge (the edge opposite the sampling edge).
- R3: cfg_res selects the sample width: 0 gives 16 bits, 1 gives 18, 2 gives 20 and 3 gives 24. Samples are right-aligned in left_data and right_data, and the bits above the width are zero.
- R4: With cfg_rjust=0 and cfg_delay=0, the first bit sampled in a word-clock phase is the sample MSB, and the remaining bits follow MSB first.
- R5: With cfg_rjust=0 and cfg_delay=1, the first bit of a phase is skipped and the second bit sampled is the MSB.
- R6: With cfg_rjust=1, the sample is the last N bits sampled before the word clock changes phase, MSB first, and cfg_delay has no effect.
- R7: With cfg_sck_inv=0, data is sampled on the rising edge of the bit clock. With cfg_sck_inv=1, it is sampled on the falling edge.
- R8: A phase is left while the word-clock level equals cfg_ws_inv and right otherwise. A pair is a left phase followed by a right phase.
- R9: In slave mode, left and right phases of unequal length, and pauses in the bit clock, do not change the captured samples as long as each phase holds enough bits.
- R10: sample_valid is high for exactly one cycle per complete pair. left_data and right_data change only in that cycle. The partial phase in progress at reset never yields a pair.
- R11: In master mode, the receiver captures the data line against the clocks it generates itself, with the same framing rules as in slave mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_master | input | 1 | 1: generate the link clocks, 0: follow sck_in and ws_in |
| cfg_div | input | DIV_W | Master bit-clock half period minus one, in clk cycles (at least 1) |
| cfg_res | input | 2 | Sample width code (16/18/20/24) |
| cfg_rjust | input | 1 | 1: data at the end of the phase, 0: at the start |
| cfg_delay | input | 1 | One-bit gap before the MSB when start-aligned |
| cfg_sck_inv | input | 1 | 0: sample on the rising edge, 1: on the falling edge |
| cfg_ws_inv | input | 1 | Word-clock level that means left |
| sck_in | input | 1 | Bit clock from a remote master |
| ws_in | input | 1 | Word clock from a remote master |
| sd_in | input | 1 | Serial data |
| sck_out | output | 1 | Generated bit clock |
| ws_out | output | 1 | Generated word clock |
| left_data | output | DATA_W | Last captured left sample |
| right_data | output | DATA_W | Last captured right sample |
| sample_valid | output | 1 | One-cycle strobe for a new pair |

## Verification
In right-justified mode, the sampling edge that carries the first bit of a new phase also closes the previous phase. On that one edge the port latches the finished word, may emit a pair, and still has to shift in the new bit. Runs that use each end-aligned width with uneven phases, and with pad ones in front of the data, make this edge fall at every pair boundary. A scoreboard then compares every emitted pair, so a word that has lost its last bit or gained a pad bit shows up at once. In start-aligned mode, the last data bit of a right phase and the pair strobe fall on the same edge. The master run checks this against data shifted out on the port's own generated clocks.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;

   localparam int PCM_W = 24;

   typedef enum logic [1:0] {
      RES_16 = 2'd0,
      RES_18 = 2'd1,
      RES_20 = 2'd2,
      RES_24 = 2'd3
   } res_e;

   function automatic int unsigned res_bits(input logic [1:0] code);
      case (res_e'(code))
         RES_16:  return 16;
         RES_18:  return 18;
         RES_20:  return 20;
         default: return 24;
      endcase
   endfunction

   function automatic logic [PCM_W-1:0] res_mask(input logic [1:0] code);
      logic [PCM_W-1:0] m;
      m = '0;
      for (int i = 0; i < PCM_W; i++) begin
         if (i < int'(res_bits(code))) m[i] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/pcm_rx_sync.sv
module pcm_rx_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pcm_rx_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("pcm_rx_sync: WIDTH must be positive");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/pcm_rx_clkgen.sv
module pcm_rx_clkgen #(
   parameter int DIV_W     = 8,
   parameter int SLOT_BITS = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [DIV_W-1:0] cfg_div,
   output logic             sck_c,
   output logic             ws_right
);

   localparam int BIT_W = (SLOT_BITS > 1) ? $clog2(SLOT_BITS) : 1;
   localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(SLOT_BITS - 1);

   generate
      if (SLOT_BITS < 2) begin : g_bad_slot
         $error("pcm_rx_clkgen: SLOT_BITS must be at least 2");
      end
   endgenerate

   logic [DIV_W-1:0] div_cnt;
   logic [BIT_W-1:0] bit_idx;
   logic             half_done;

   assign half_done = (div_cnt == cfg_div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_cnt  <= '0;
         sck_c    <= 1'b0;
         ws_right <= 1'b0;
         bit_idx  <= '0;
      end else if (!en) begin
         div_cnt  <= '0;
         sck_c    <= 1'b0;
         ws_right <= 1'b0;
         bit_idx  <= '0;
      end else if (half_done) begin
         div_cnt <= '0;
         sck_c   <= ~sck_c;
         if (sck_c) begin
            // launch edge: advance bit position, switch phase at slot end
            if (bit_idx == LAST_BIT) begin
               bit_idx  <= '0;
               ws_right <= ~ws_right;
            end else begin
               bit_idx <= bit_idx + 1'b1;
            end
         end
      end else begin
         div_cnt <= div_cnt + 1'b1;
      end
   end

endmodule

// File: rtl/pcm_rx_deser.sv
module pcm_rx_deser #(
   parameter int DATA_W = 24,
   parameter int CNT_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck_s,
   input  logic              ws_s,
   input  logic              sd_s,
   input  logic              cfg_sck_inv,
   input  logic              cfg_ws_inv,
   input  logic              cfg_rjust,
   input  logic              cfg_delay,
   input  logic [1:0]        cfg_res,
   output logic [DATA_W-1:0] left_data,
   output logic [DATA_W-1:0] right_data,
   output logic              sample_valid
);
   import pcm_rx_pkg::*;

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   generate
      if ((2 ** CNT_W) <= (PCM_W + 2)) begin : g_bad_cnt
         $error("pcm_rx_deser: CNT_W too small for the widest sample");
      end
   endgenerate

   logic              sck_prev;
   logic              have_prev;
   logic              ws_prev;
   logic              locked;
   logic              left_got;
   logic [CNT_W-1:0]  idx;
   logic [DATA_W-1:0] acc;
   logic [DATA_W-1:0] shreg;
   logic [DATA_W-1:0] left_hold;

   logic              samp;
   logic              is_left;
   logic              change;
   logic              active;
   logic [CNT_W-1:0]  k;
   logic [CNT_W-1:0]  nbits;
   logic [CNT_W-1:0]  first_bit;
   logic [CNT_W-1:0]  last_bit;
   logic              in_data;
   logic [DATA_W-1:0] acc_base;
   logic [DATA_W-1:0] acc_next;
   logic [DATA_W-1:0] mask;
   logic              lj_done;
   logic              rj_done;
   logic              done_is_left;
   logic [DATA_W-1:0] word_done;

   always_comb begin
      samp      = (sck_s ^ cfg_sck_inv) && !(sck_prev ^ cfg_sck_inv);
      is_left   = (ws_s == cfg_ws_inv);
      change    = have_prev && (is_left != ws_prev);
      active    = locked || change;
      k         = change ? '0 : idx;
      nbits     = CNT_W'(res_bits(cfg_res));
      first_bit = {{(CNT_W-1){1'b0}}, cfg_delay};
      last_bit  = first_bit + nbits - CNT_W'(1);
      in_data   = (k >= first_bit) && (k <= last_bit);
      acc_base  = change ? '0 : acc;
      acc_next  = in_data ? {acc_base[DATA_W-2:0], sd_s} : acc_base;
      mask      = DATA_W'(res_mask(cfg_res));
      lj_done   = !cfg_rjust && (k == last_bit);
      rj_done   = cfg_rjust && change && locked;
      done_is_left = lj_done ? is_left : ws_prev;
      word_done    = lj_done ? acc_next : (shreg & mask);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_prev     <= 1'b0;
         have_prev    <= 1'b0;
         ws_prev      <= 1'b0;
         locked       <= 1'b0;
         left_got     <= 1'b0;
         idx          <= '0;
         acc          <= '0;
         shreg        <= '0;
         left_hold    <= '0;
         left_data    <= '0;
         right_data   <= '0;
         sample_valid <= 1'b0;
      end else begin
         sample_valid <= 1'b0;
         sck_prev     <= sck_s;
         if (samp) begin
            have_prev <= 1'b1;
            ws_prev   <= is_left;
            if (change) locked <= 1'b1;
            if (active) begin
               idx   <= (k == CNT_MAX) ? k : k + 1'b1;
               acc   <= acc_next;
               shreg <= {shreg[DATA_W-2:0], sd_s};
               if (lj_done || rj_done) begin
                  if (done_is_left) begin
                     left_hold <= word_done;
                     left_got  <= 1'b1;
                  end else if (left_got) begin
                     left_data    <= left_hold;
                     right_data   <= word_done;
                     sample_valid <= 1'b1;
                     left_got     <= 1'b0;
                  end
               end
            end
         end
      end
   end

endmodule

// File: rtl/pcm_rx_port.sv
module pcm_rx_port #(
   parameter int DATA_W      = 24,
   parameter int SLOT_BITS   = 32,
   parameter int DIV_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter int CNT_W       = 6,
   parameter bit HAS_MASTER  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_master,
   input  logic [DIV_W-1:0]  cfg_div,
   input  logic [1:0]        cfg_res,
   input  logic              cfg_rjust,
   input  logic              cfg_delay,
   input  logic              cfg_sck_inv,
   input  logic              cfg_ws_inv,
   input  logic              sck_in,
   input  logic              ws_in,
   input  logic              sd_in,
   output logic              sck_out,
   output logic              ws_out,
   output logic [DATA_W-1:0] left_data,
   output logic [DATA_W-1:0] right_data,
   output logic              sample_valid
);
   import pcm_rx_pkg::*;

   localparam int LINK_W = 3;

   generate
      if (DATA_W < PCM_W) begin : g_bad_data_w
         $error("pcm_rx_port: DATA_W must hold the widest sample");
      end
      if (SLOT_BITS < PCM_W + 1) begin : g_bad_slot
         $error("pcm_rx_port: SLOT_BITS must fit the widest sample plus delay");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("pcm_rx_port: DIV_W must be positive");
      end
   endgenerate

   logic              master_en;
   logic              gen_sck;
   logic              gen_ws_right;
   logic [LINK_W-1:0] link_raw;
   logic [LINK_W-1:0] link_sync;

   generate
      if (HAS_MASTER) begin : g_master
         pcm_rx_clkgen #(
            .DIV_W     (DIV_W),
            .SLOT_BITS (SLOT_BITS)
         ) u_clkgen (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (cfg_master),
            .cfg_div  (cfg_div),
            .sck_c    (gen_sck),
            .ws_right (gen_ws_right)
         );
         assign master_en = cfg_master;
      end else begin : g_slave_only
         assign gen_sck      = 1'b0;
         assign gen_ws_right = 1'b0;
         assign master_en    = 1'b0;
      end
   endgenerate

   assign sck_out = gen_sck ^ cfg_sck_inv;
   assign ws_out  = gen_ws_right ^ cfg_ws_inv;

   // generated clocks loop back through the same synchroniser as the data
   assign link_raw = {master_en ? sck_out : sck_in,
                      master_en ? ws_out  : ws_in,
                      sd_in};

   pcm_rx_sync #(
      .WIDTH  (LINK_W),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (link_raw),
      .q     (link_sync)
   );

   pcm_rx_deser #(
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W)
   ) u_deser (
      .clk          (clk),
      .rst_n        (rst_n),
      .sck_s        (link_sync[2]),
      .ws_s         (link_sync[1]),
      .sd_s         (link_sync[0]),
      .cfg_sck_inv  (cfg_sck_inv),
      .cfg_ws_inv   (cfg_ws_inv),
      .cfg_rjust    (cfg_rjust),
      .cfg_delay    (cfg_delay),
      .cfg_res      (cfg_res),
      .left_data    (left_data),
      .right_data   (right_data),
      .sample_valid (sample_valid)
   );

endmodule

// File: rtl/pcm_rx_port_chk.sv
module pcm_rx_port_chk #(
   parameter int DATA_W = 24,
   parameter int DIV_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_master,
   input logic [DIV_W-1:0]  cfg_div,
   input logic [1:0]        cfg_res,
   input logic              cfg_sck_inv,
   input logic              sck_out,
   input logic              ws_out,
   input logic [DATA_W-1:0] left_data,
   input logic [DATA_W-1:0] right_data,
   input logic              sample_valid
);
   import pcm_rx_pkg::*;

   logic             primed;
   logic             seen;
   logic             sck_q;
   logic             ws_q;
   logic [DIV_W:0]   run;
   logic             sck_moved;

   assign sck_moved = primed && (sck_out != sck_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         primed <= 1'b0;
         seen   <= 1'b0;
         sck_q  <= 1'b0;
         ws_q   <= 1'b0;
         run    <= '0;
      end else begin
         primed <= 1'b1;
         sck_q  <= sck_out;
         ws_q   <= ws_out;
         if (sck_moved) begin
            run  <= '0;
            seen <= 1'b1;
         end else if (run != '1) begin
            run <= run + 1'b1;
         end
      end
   end

   // R10
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sample_valid |=> !sample_valid);

   // R10
   data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_valid |-> ($stable(left_data) && $stable(right_data)));

   // R3
   width_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sample_valid |-> (((left_data | right_data) & ~DATA_W'(res_mask(cfg_res))) == '0));

   // R2
   sck_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_master && seen && sck_moved) |-> (run == {1'b0, cfg_div}));

   // R2
   ws_on_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_master && primed && (ws_out != ws_q)) |->
         ((sck_q ^ cfg_sck_inv) && !(sck_out ^ cfg_sck_inv)));

endmodule

bind pcm_rx_port pcm_rx_port_chk #(
   .DATA_W (DATA_W),
   .DIV_W  (DIV_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_master   (cfg_master),
   .cfg_div      (cfg_div),
   .cfg_res      (cfg_res),
   .cfg_sck_inv  (cfg_sck_inv),
   .sck_out      (sck_out),
   .ws_out       (ws_out),
   .left_data    (left_data),
   .right_data   (right_data),
   .sample_valid (sample_valid)
);

// File: tb/pcm_rx_port_test.sv
module pcm_rx_port_test;

   localparam int DATA_W = 24;
   localparam int SLOT   = 32;
   localparam int DIV_W  = 8;
   localparam int HALF   = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_master = 1'b0;
   logic [DIV_W-1:0]  cfg_div = 8'd2;
   logic [1:0]        cfg_res = 2'd0;
   logic              cfg_rjust = 1'b0;
   logic              cfg_delay = 1'b0;
   logic              cfg_sck_inv = 1'b0;
   logic              cfg_ws_inv = 1'b0;
   logic              sck_in = 1'b0;
   logic              ws_in = 1'b0;
   logic              sd_in = 1'b0;
   logic              sck_out;
   logic              ws_out;
   logic [DATA_W-1:0] left_data;
   logic [DATA_W-1:0] right_data;
   logic              sample_valid;

   always #2 clk = ~clk;

   pcm_rx_port #(.DATA_W(DATA_W), .SLOT_BITS(SLOT), .DIV_W(DIV_W)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_div(cfg_div),
      .cfg_res(cfg_res), .cfg_rjust(cfg_rjust), .cfg_delay(cfg_delay),
      .cfg_sck_inv(cfg_sck_inv), .cfg_ws_inv(cfg_ws_inv),
      .sck_in(sck_in), .ws_in(ws_in), .sd_in(sd_in),
      .sck_out(sck_out), .ws_out(ws_out),
      .left_data(left_data), .right_data(right_data), .sample_valid(sample_valid)
   );

   int checks = 0;
   int fails  = 0;
   int hold_err = 0;

   logic [DATA_W-1:0] exp_l[$];
   logic [DATA_W-1:0] exp_r[$];
   string             exp_t[$];

   task automatic check(input bit ok, input string tag, input string what,
                        input longint act, input longint expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
      end
   endtask

   task automatic finish_up();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   function automatic int nbits(input logic [1:0] code);
      case (code)
         2'd0:    return 16;
         2'd1:    return 18;
         2'd2:    return 20;
         default: return 24;
      endcase
   endfunction

   function automatic logic [DATA_W-1:0] wmask(input logic [1:0] code);
      return DATA_W'((64'd1 << nbits(code)) - 64'd1);
   endfunction

   // monitor: pops the scoreboard on every strobe
   logic              prev_v = 1'b0;
   logic [DATA_W-1:0] last_l = '0;
   logic [DATA_W-1:0] last_r = '0;

   always @(negedge clk) begin
      if (!rst_n) begin
         prev_v = 1'b0;
         last_l = '0;
         last_r = '0;
      end else begin
         if (sample_valid) begin
            if (prev_v) check(1'b0, "R10", "strobe longer than one cycle", 1, 0);
            if (exp_l.size() == 0) begin
               check(1'b0, "R10", "strobe with no pair expected", 1, 0);
            end else begin
               string t;
               logic [DATA_W-1:0] el, er;
               t  = exp_t.pop_front();
               el = exp_l.pop_front();
               er = exp_r.pop_front();
               check(left_data == el, t, "left sample", left_data, el);
               check(right_data == er, t, "right sample", right_data, er);
            end
            last_l = left_data;
            last_r = right_data;
         end else if (left_data != last_l || right_data != last_r) begin
            hold_err++;
         end
         prev_v = sample_valid;
      end
   end

   // master-mode transmitter, reacting to the generated clocks (R11)
   logic [DATA_W-1:0] ml[3];
   logic [DATA_W-1:0] mr[3];
   bit m_prev_canon = 1'b0;
   bit m_prev_left  = 1'b1;
   bit m_seen_right = 1'b0;
   int m_idx  = 0;
   int m_pair = -1;

   always @(negedge clk) begin
      if (!rst_n || !cfg_master) begin
         m_prev_canon = 1'b0;
         m_prev_left  = 1'b1;
         m_seen_right = 1'b0;
         m_idx        = 0;
         m_pair       = -1;
      end else begin
         bit canon, lft;
         canon = sck_out ^ cfg_sck_inv;
         lft   = (ws_out == cfg_ws_inv);
         if (m_prev_canon && !canon) begin
            if (lft != m_prev_left) begin
               m_idx = 0;
               if (!lft) m_seen_right = 1'b1;
               else if (m_seen_right) m_pair++;
            end else begin
               m_idx++;
            end
            m_prev_left = lft;
            if (m_pair >= 0 && m_pair < 3 && m_idx >= int'(cfg_delay) &&
                m_idx < int'(cfg_delay) + nbits(cfg_res)) begin
               logic [DATA_W-1:0] w;
               w = lft ? ml[m_pair] : mr[m_pair];
               sd_in = w[nbits(cfg_res) - 1 - (m_idx - int'(cfg_delay))];
            end else begin
               sd_in = 1'b0;
            end
         end
         m_prev_canon = canon;
      end
   end

   task automatic apply_reset();
      rst_n  = 1'b0;
      sck_in = cfg_sck_inv;
      ws_in  = ~cfg_ws_inv;
      sd_in  = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   // slave driver: one word-clock phase; pad bits are ones
   task automatic drive_phase(input bit left, input logic [DATA_W-1:0] w,
                              input int plen, input bit gaps);
      int n;
      n = nbits(cfg_res);
      for (int k = 0; k < plen; k++) begin
         logic b;
         if (cfg_rjust)
            b = (k >= plen - n) ? w[n - 1 - (k - (plen - n))] : 1'b1;
         else
            b = (k >= int'(cfg_delay) && k < int'(cfg_delay) + n) ?
                w[n - 1 - (k - int'(cfg_delay))] : 1'b1;
         sck_in = cfg_sck_inv;
         ws_in  = left ? cfg_ws_inv : ~cfg_ws_inv;
         sd_in  = b;
         repeat (HALF) @(negedge clk);
         sck_in = ~cfg_sck_inv;
         repeat (HALF) @(negedge clk);
         if (gaps && (k % 5 == 2)) repeat (7) @(negedge clk);
      end
   endtask

   task automatic run_slave(input string tag, input logic [1:0] res, input bit rj,
                            input bit dly, input bit sinv, input bit winv,
                            input int pl, input int pr, input bit gaps, input int seed);
      cfg_master  = 1'b0;
      cfg_res     = res;
      cfg_rjust   = rj;
      cfg_delay   = dly;
      cfg_sck_inv = sinv;
      cfg_ws_inv  = winv;
      apply_reset();
      drive_phase(1'b0, '0, 4, 1'b0);
      for (int p = 0; p < 3; p++) begin
         logic [DATA_W-1:0] l, r;
         l = wmask(res) & DATA_W'(32'h9E37_79B1 * (seed * 4 + p + 1));
         r = wmask(res) & DATA_W'(32'h7F4A_7C15 * (seed * 4 + p + 2));
         exp_l.push_back(l);
         exp_r.push_back(r);
         exp_t.push_back(tag);
         drive_phase(1'b1, l, pl, gaps);
         drive_phase(1'b0, r, pr, gaps);
      end
      drive_phase(1'b1, '0, 1, 1'b0);
      repeat (20) @(negedge clk);
      check(exp_l.size() == 0, tag, "pairs still outstanding", exp_l.size(), 0);
      exp_l.delete();
      exp_r.delete();
      exp_t.delete();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
   end

   initial begin
      // master run: start-aligned with delay, 24 bits, inverted bit clock
      cfg_master  = 1'b1;
      cfg_div     = 8'd2;
      cfg_res     = 2'd3;
      cfg_rjust   = 1'b0;
      cfg_delay   = 1'b1;
      cfg_sck_inv = 1'b1;
      cfg_ws_inv  = 1'b0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(sample_valid == 1'b0, "R1", "sample_valid in reset", sample_valid, 0);
      check(left_data == '0 && right_data == '0, "R1", "data in reset", left_data | right_data, 0);
      check(sck_out == cfg_sck_inv, "R1", "sck_out in reset", sck_out, cfg_sck_inv);
      check(ws_out == cfg_ws_inv, "R1", "ws_out in reset", ws_out, cfg_ws_inv);
      for (int p = 0; p < 3; p++) begin
         ml[p] = DATA_W'(32'hC3A5_5A3C + p * 32'h0011_3571);
         mr[p] = DATA_W'(32'h0F1E_2D4B ^ (p * 32'h0080_0401));
         exp_l.push_back(ml[p]);
         exp_r.push_back(mr[p]);
         exp_t.push_back("R11/R5");
      end
      rst_n = 1'b1;
      begin
         int t0, t1, guard;
         bit c_prev, c_now;
         // R2 bit-clock period: rise to rise of the sampling edge
         c_prev = sck_out ^ cfg_sck_inv;
         t0 = -1; t1 = -1; guard = 0;
         while (t1 < 0 && guard < 200) begin
            @(negedge clk);
            guard++;
            c_now = sck_out ^ cfg_sck_inv;
            if (c_now && !c_prev) begin
               if (t0 < 0) t0 = guard; else t1 = guard;
            end
            c_prev = c_now;
         end
         check(t1 - t0 == 2 * (int'(cfg_div) + 1), "R2", "bit-clock period",
               t1 - t0, 2 * (int'(cfg_div) + 1));
         // R2 word-clock half period
         begin
            bit w_prev;
            w_prev = ws_out;
            t0 = -1; t1 = -1; guard = 0;
            while (t1 < 0 && guard < 2000) begin
               @(negedge clk);
               guard++;
               if (ws_out != w_prev) begin
                  if (t0 < 0) t0 = guard; else t1 = guard;
               end
               w_prev = ws_out;
            end
            check(t1 - t0 == SLOT * 2 * (int'(cfg_div) + 1), "R2", "word-clock phase length",
                  t1 - t0, SLOT * 2 * (int'(cfg_div) + 1));
         end
         guard = 0;
         while (exp_l.size() != 0 && guard < 5000) begin
            @(negedge clk);
            guard++;
         end
         check(exp_l.size() == 0, "R11", "master pairs outstanding", exp_l.size(), 0);
         exp_l.delete(); exp_r.delete(); exp_t.delete();
      end

      // slave runs
      run_slave("R4/R3/R8",      2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 32, 32, 1'b0, 1);
      run_slave("R5/R7/R9",      2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 20, 28, 1'b1, 2);
      run_slave("R6/R3",         2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 24, 32, 1'b0, 3);
      run_slave("R6/R7/R8/R9",   2'd3, 1'b1, 1'b0, 1'b1, 1'b1, 30, 25, 1'b1, 4);

      check(hold_err == 0, "R10", "outputs changed without strobe", hold_err, 0);
      finish_up();
   end

endmodule